// File: doc/BRIEF.md
# Shift-Accumulate Column Processing Unit

This block is a row of small arithmetic lanes, one per image column, that multiply each column's sample by a programmable fixed-point coefficient without a multiplier. Each lane holds a working register and an accumulator. A load copies the column sample into the working register. A chain of exact halvings then scales the working register down. An add or a subtract, placed between the halvings, folds the current working value into the accumulator. The coefficient is set by the position of the adds and subtracts in the chain, in the way a bit-stream converter builds a value from weighted bits.

All lanes share one micro-operation stream and execute the same operation in the same cycle, each on its own sample. An external sequencer presents one operation per cycle with a valid strobe and marks the last operation of a programme. The block reports busy while a programme is open, gives a one-cycle done pulse after its last operation, and exposes every lane's accumulator and a sticky overflow flag.

Top module: `colproc_array`

## Requirements
- R1: After synchronous reset every accumulator reads zero, every overflow flag is clear, and both busy and done are low.
- R2: Operation code 1 (load) sets the working register to the lane's sample scaled by 2^FRAC (FRAC fractional bits, default 8) and leaves the accumulator unchanged.
- R3: Operation code 2 (halve) shifts the working register right by one place, arithmetically, so each halving is exact while fraction bits remain and otherwise truncates toward negative infinity.
- R4: Operation code 3 (zero) clears the working register, so a following add leaves the accumulator unchanged.
- R5: Operation code 4 (add) adds the sign-extended working register to the accumulator and code 5 (subtract) takes it away; the working register keeps its value.
- R6: When an add or subtract leaves the signed accumulator range, the accumulator holds the nearest rail (2^(ACC_W-1)-1 or -2^(ACC_W-1)) and that lane's overflow flag sets and stays set through later operations.
- R7: Operation code 6 (clear accumulator) zeroes the accumulator and the overflow flag of every lane and keeps the working register, so a following add yields the kept working value.
- R8: All lanes execute each operation in the same cycle, each on its own sample, with no interaction between lanes.
- R9: An operation presented with valid high takes effect at that clock edge and is visible on the outputs in the next cycle; an operation with the last flag low raises busy, and one with the last flag high drops busy and pulses done for exactly that following cycle.
- R10: With valid low, and for codes 0 and 7, no lane state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | NCOL*SAMP_W | Signed samples, lane k at bits k*SAMP_W upward |
| op_i | input | 3 | Micro-operation code |
| op_valid_i | input | 1 | Operation strobe |
| last_i | input | 1 | Marks the last operation of a programme |
| busy_o | output | 1 | Programme in progress |
| done_o | output | 1 | One-cycle pulse after the last operation |
| acc_o | output | NCOL*ACC_W | Signed accumulators with FRAC fraction bits, lane k at bits k*ACC_W upward |
| ovf_o | output | NCOL | Sticky saturation flag per lane |

## Verification
The assertions assume that the inputs are stable and defined at each rising edge and that the accumulator is wider than the working register, so a single add can move it by at most one rail crossing. They also take the last flag to be meaningful only when valid is high. The stimulus drives every input on the falling edge from a fixed-seed random stream over all eight codes, valid held low part of the time, and directed runs that push the accumulator into both rails.

// File: rtl/colproc_pkg.sv
package colproc_pkg;
  localparam logic [2:0] OPC_NOP    = 3'd0;
  localparam logic [2:0] OPC_LOAD   = 3'd1;
  localparam logic [2:0] OPC_HALVE  = 3'd2;
  localparam logic [2:0] OPC_ZERO   = 3'd3;
  localparam logic [2:0] OPC_ADD    = 3'd4;
  localparam logic [2:0] OPC_SUB    = 3'd5;
  localparam logic [2:0] OPC_CLRACC = 3'd6;

  typedef struct packed {
    logic load;
    logic halve;
    logic zero;
    logic add;
    logic sub;
    logic clr;
  } uop_t;
endpackage

// File: rtl/colproc_seq.sv
module colproc_seq
  import colproc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] op_i,
  input  logic       op_valid_i,
  input  logic       last_i,
  output uop_t       uop_o,
  output logic       busy_o,
  output logic       done_o
);
  always_comb begin
    uop_o = '0;
    if (op_valid_i) begin
      case (op_i)
        OPC_LOAD:   uop_o.load  = 1'b1;
        OPC_HALVE:  uop_o.halve = 1'b1;
        OPC_ZERO:   uop_o.zero  = 1'b1;
        OPC_ADD:    uop_o.add   = 1'b1;
        OPC_SUB:    uop_o.sub   = 1'b1;
        OPC_CLRACC: uop_o.clr   = 1'b1;
        default:    uop_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= op_valid_i && last_i;
      if (op_valid_i) busy_o <= !last_i;
    end
  end
endmodule

// File: rtl/colproc_lane.sv
module colproc_lane
  import colproc_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int FRAC   = 8,
  parameter int ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  uop_t                     uop_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     ovf_o
);
  localparam int WORK_W = SAMP_W + FRAC;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [WORK_W-1:0] work_q;
  logic signed [ACC_W:0]    acc_x, work_x, sum_x;
  logic                     wrap;
  logic signed [ACC_W-1:0]  acc_next;

  always_comb begin
    acc_x  = {acc_o[ACC_W-1], acc_o};
    work_x = {{(ACC_W+1-WORK_W){work_q[WORK_W-1]}}, work_q};
    sum_x  = uop_i.sub ? (acc_x - work_x) : (acc_x + work_x);
    wrap   = sum_x[ACC_W] != sum_x[ACC_W-1];
    if (wrap) acc_next = sum_x[ACC_W] ? ACC_MIN : ACC_MAX;
    else      acc_next = sum_x[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      acc_o  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (uop_i.load)       work_q <= {samp_i, {FRAC{1'b0}}};
      else if (uop_i.halve) work_q <= work_q >>> 1;
      else if (uop_i.zero)  work_q <= '0;

      if (uop_i.clr) begin
        acc_o <= '0;
        ovf_o <= 1'b0;
      end else if (uop_i.add || uop_i.sub) begin
        acc_o <= acc_next;
        if (wrap) ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/colproc_array.sv
module colproc_array
  import colproc_pkg::*;
#(
  parameter int NCOL   = 4,
  parameter int SAMP_W = 10,
  parameter int FRAC   = 8,
  parameter int ACC_W  = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCOL*SAMP_W-1:0] samp_i,
  input  logic [2:0]             op_i,
  input  logic                   op_valid_i,
  input  logic                   last_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NCOL*ACC_W-1:0]  acc_o,
  output logic [NCOL-1:0]        ovf_o
);
  uop_t uop;

  colproc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .op_valid_i (op_valid_i),
    .last_i     (last_i),
    .uop_o      (uop),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  for (genvar k = 0; k < NCOL; k++) begin : g_lane
    colproc_lane #(
      .SAMP_W (SAMP_W),
      .FRAC   (FRAC),
      .ACC_W  (ACC_W)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .uop_i  (uop),
      .samp_i (samp_i[k*SAMP_W +: SAMP_W]),
      .acc_o  (acc_o[k*ACC_W +: ACC_W]),
      .ovf_o  (ovf_o[k])
    );
  end
endmodule

// File: rtl/colproc_chk.sv
module colproc_chk
  import colproc_pkg::*;
#(
  parameter int NCOL  = 4,
  parameter int ACC_W = 24
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2:0]            op_i,
  input logic                  op_valid_i,
  input logic                  last_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [NCOL*ACC_W-1:0] acc_o,
  input logic [NCOL-1:0]       ovf_o
);
  localparam logic [ACC_W-1:0] TOP = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] BOT = {1'b1, {(ACC_W-1){1'b0}}};

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R9
  AST_OPEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !last_i) |=> (busy_o && !done_o)); // R9
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && last_i) |=> done_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> ($stable(acc_o) && $stable(ovf_o))); // R10
  AST_LOAD_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i == OPC_LOAD) |=> $stable(acc_o)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i == OPC_CLRACC) |=> (acc_o == '0 && ovf_o == '0)); // R7

  for (genvar k = 0; k < NCOL; k++) begin : g_ln
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovf_o[k] && !(op_valid_i && op_i == OPC_CLRACC)) |=> ovf_o[k]); // R6
    AST_SAT_RAIL: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf_o[k]) |-> (acc_o[k*ACC_W +: ACC_W] == TOP ||
                           acc_o[k*ACC_W +: ACC_W] == BOT)); // R6
  end
endmodule

bind colproc_array colproc_chk #(.NCOL(NCOL), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .op_valid_i (op_valid_i),
  .last_i     (last_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .acc_o      (acc_o),
  .ovf_o      (ovf_o)
);

// File: tb/sim_colproc_array.sv
`timescale 1ns/1ps
module sim_colproc_array;
  localparam int NCOL = 4, SW = 10, FR = 8, AW = 24;
  localparam longint AMAX = (64'sd1 <<< (AW-1)) - 1;
  localparam longint AMIN = -(64'sd1 <<< (AW-1));

  logic clk = 1'b0, rst = 1'b1;
  logic [NCOL*SW-1:0] samp;
  logic [2:0] op;
  logic valid, last;
  logic busy, done;
  logic [NCOL*AW-1:0] acc;
  logic [NCOL-1:0] ovf;

  always #2 clk = ~clk;

  colproc_array #(.NCOL(NCOL), .SAMP_W(SW), .FRAC(FR), .ACC_W(AW)) u0 (
    .clk(clk), .rst(rst), .samp_i(samp), .op_i(op), .op_valid_i(valid),
    .last_i(last), .busy_o(busy), .done_o(done), .acc_o(acc), .ovf_o(ovf));

  int errors = 0, checks = 0;
  longint m_work [NCOL];
  longint m_acc [NCOL];
  logic m_ovf [NCOL];
  logic m_busy, m_done;
  logic signed [SW-1:0] s_q [NCOL];

  function automatic longint sat(input longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  task automatic model(input logic [2:0] o, input logic v, input logic l);
    m_done = v && l;
    if (v) m_busy = !l;
    if (!v) return;
    for (int k = 0; k < NCOL; k++) begin
      longint r;
      case (o)
        3'd1: m_work[k] = longint'(s_q[k]) * (64'sd1 <<< FR);
        3'd2: m_work[k] = m_work[k] >>> 1;
        3'd3: m_work[k] = 0;
        3'd4, 3'd5: begin
          r = (o == 3'd4) ? m_acc[k] + m_work[k] : m_acc[k] - m_work[k];
          if (r != sat(r)) m_ovf[k] = 1'b1;
          m_acc[k] = sat(r);
        end
        3'd6: begin m_acc[k] = 0; m_ovf[k] = 1'b0; end
        default: ;
      endcase
    end
  endtask

  task automatic compare(input string req);
    logic bad;
    bad = (busy !== m_busy) || (done !== m_done);
    for (int k = 0; k < NCOL; k++)
      if (longint'($signed(acc[k*AW +: AW])) != m_acc[k] || ovf[k] !== m_ovf[k]) bad = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      for (int k = 0; k < NCOL; k++)
        $display("FAIL %s lane%0d acc=%0d ovf=%0b busy=%0b done=%0b expected acc=%0d ovf=%0b busy=%0b done=%0b",
          req, k, $signed(acc[k*AW +: AW]), ovf[k], busy, done, m_acc[k], m_ovf[k], m_busy, m_done);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic v, input logic l, input string req);
    @(negedge clk);
    for (int k = 0; k < NCOL; k++) samp[k*SW +: SW] = s_q[k];
    op = o; valid = v; last = l;
    model(o, v, l);
    @(negedge clk);
    valid = 1'b0; last = 1'b0;
    compare(req);
  endtask

  task automatic set_all(input int v);
    for (int k = 0; k < NCOL; k++) s_q[k] = SW'(v);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    samp = '0; op = '0; valid = 1'b0; last = 1'b0;
    for (int k = 0; k < NCOL; k++) begin
      m_work[k] = 0; m_acc[k] = 0; m_ovf[k] = 1'b0; s_q[k] = '0;
    end
    m_busy = 1'b0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    compare("R1 reset");
    // R2 R3 R5 R9: 100 * 1/8 on every lane, then distinct lanes (R8)
    set_all(100);
    issue(3'd1, 1, 0, "R2 load keeps acc");
    for (int i = 0; i < 3; i++) issue(3'd2, 1, 0, "R3 halve");
    issue(3'd4, 1, 0, "R5 add");
    issue(3'd5, 1, 1, "R9 last op done");
    issue(3'd0, 0, 0, "R9 done one cycle");
    for (int k = 0; k < NCOL; k++) s_q[k] = SW'(k*37 - 60);
    issue(3'd1, 1, 0, "R8 per lane load");
    issue(3'd4, 1, 0, "R8 per lane add");
    // R3 floor on negative
    set_all(-3);
    issue(3'd6, 1, 0, "R7 clear");
    issue(3'd1, 1, 0, "R2 load negative");
    for (int i = 0; i < 9; i++) issue(3'd2, 1, 0, "R3 halve floor");
    issue(3'd4, 1, 0, "R3 floor add gives -2");
    // R4 zero then add unchanged
    issue(3'd3, 1, 0, "R4 zero");
    issue(3'd4, 1, 0, "R4 add after zero");
    // R7 clear keeps work
    set_all(25);
    issue(3'd1, 1, 0, "R2 load");
    issue(3'd6, 1, 0, "R7 clear acc");
    issue(3'd4, 1, 1, "R7 work kept");
    // R10 unused code and invalid
    issue(3'd7, 1, 0, "R10 code 7");
    issue(3'd0, 1, 0, "R10 code 0");
    issue(3'd4, 0, 0, "R10 valid low");
    // R6 positive rail
    set_all(511);
    issue(3'd6, 1, 0, "R7 clear");
    issue(3'd1, 1, 0, "R2 load max");
    for (int i = 0; i < 70; i++) issue(3'd4, 1, 0, "R6 saturate high");
    issue(3'd5, 1, 0, "R6 sticky after sub");
    issue(3'd6, 1, 0, "R7 clears ovf");
    set_all(-512);
    issue(3'd1, 1, 0, "R2 load min");
    for (int i = 0; i < 70; i++) issue(3'd4, 1, 1, "R6 saturate low");
    issue(3'd6, 1, 1, "R7 clear");
    // random
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < NCOL; k++) s_q[k] = SW'($urandom);
      issue(3'($urandom), ($urandom % 10) != 0, ($urandom % 6) == 0, "R8 random stream");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule